// File: doc/BRIEF.md
# Shared Coprocessor Word Store

A single word store of 2^ADDR_W 32-bit entries sits between a coprocessor and a host. Neither side addresses the store directly. Each side writes a pointer register and then streams words through a data register. Every data access moves the pointer on by one, so a block can be read or written without reloading the address.

The coprocessor sees a small 32-bit I/O space. Bit 0 of its I/O address selects the pointer register (0) or the data register (1). The upper bits select one of CP_SETS independent pointer sets, so four sets sit at offsets 0x00, 0x08, 0x10 and 0x18. A data access through one set advances that set only. The host sees a 16-bit port that moves each word as two halves. A low-half write is held in a latch, and the high-half write commits the whole word. Host pointer bit 15 decides whether the pointer steps after the high half.

A synchronous reset zeroes all pointers and the latch. It then starts a sweep that writes zero to every entry, one entry per cycle. The coprocessor wins when both sides want the store in the same cycle, and the host is held off through a ready signal.

Top module: `coram_window`

## Requirements
- R1: While `rst` is high and for exactly 2^ADDR_W cycles after it falls, `clr_busy` is 1. After that every entry reads 0, every pointer reads 0 and the host low-half latch is 0.
- R2: While `clr_busy` is 1, `h_ready` is 0 and any request on either side has no effect: no valid strobe, no store write and no pointer change.
- R3: A coprocessor access with `cp_addr[0]`=0 reaches the pointer of set `cp_addr[4:3]`. A read returns that pointer. A write replaces byte k of it with byte k of `cp_wdata` where `cp_be[k]`=1. An access with `cp_addr[2:1]` non-zero has no effect and gives no `cp_rvalid`.
- R4: A coprocessor read with `cp_addr[0]`=1 raises `cp_rvalid` one cycle later with the entry at the selected pointer on `cp_rdata`. Only that set's pointer increments.
- R5: A coprocessor write with `cp_addr[0]`=1 merges `cp_wdata` into the entry at the selected pointer under `cp_be`. Only that set's pointer increments.
- R6: Host offset 2 (`h_sel`=2) is a 16-bit pointer register that can be written and read back. A host read of offset 3 returns 0 and changes nothing.
- R7: Host reads at `h_sel`=0 and `h_sel`=1 return bits 15:0 and bits 31:16 of the entry at the host pointer, one cycle later with `h_rvalid`.
- R8: The host pointer increments after a high-half access (read or write) only when its bit 15 is 1. It never increments after a low-half access.
- R9: A host write to `h_sel`=0 only loads the latch. A host write to `h_sel`=1 stores {`h_wdata`, latch} as one word.
- R10: If the coprocessor data register and a host store access (low read, high read or high write) are requested in the same cycle, the coprocessor is served and `h_ready` is 0. A held host request is served in the next free cycle.
- R11: Store addressing uses only the low ADDR_W bits of a pointer. The upper pointer bits are kept and read back, but they do not change which entry is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the clear sweep |
| cp_req | input | 1 | Coprocessor access strobe, one cycle per access |
| cp_we | input | 1 | Coprocessor write (1) or read (0) |
| cp_addr | input | 5 | Coprocessor I/O address: bit 0 pointer/data, bits 2:1 must be 0, bits 4:3 set |
| cp_be | input | 4 | Coprocessor byte enables for writes |
| cp_wdata | input | 32 | Coprocessor write data |
| cp_rdata | output | 32 | Coprocessor read data, valid with cp_rvalid |
| cp_rvalid | output | 1 | Coprocessor read result valid |
| h_req | input | 1 | Host access request, held until accepted |
| h_we | input | 1 | Host write (1) or read (0) |
| h_sel | input | 2 | Host offset: 0 low half, 1 high half, 2 pointer, 3 unused |
| h_wdata | input | 16 | Host write data |
| h_ready | output | 1 | Host request accepted this cycle |
| h_rdata | output | 16 | Host read data, valid with h_rvalid |
| h_rvalid | output | 1 | Host read result valid |
| clr_busy | output | 1 | Clear sweep in progress |

## Verification
Every read result, on either side, is due on the first clock edge after the accepting edge. Pointer increments and store writes also take effect on that edge. The bench drives requests just after a falling edge and samples valid and data at the next falling edge. It compares them with a model that updates in the same order. `h_ready` is combinational, so it is sampled a moment after the drive, before the rising edge that would accept the request. In the collision case the host result is due one cycle later than usual, and the bench samples it there. The clear sweep length is checked by counting falling edges with `clr_busy` high from the release of reset.

// File: rtl/coram_pkg.sv
package coram_pkg;

    localparam int WORD_W        = 32;
    localparam int HALF_W        = 16;
    localparam int LANES         = WORD_W / 8;
    localparam int HOST_STEP_BIT = 15;

    typedef enum logic [1:0] {
        H_DATA_LO = 2'd0,
        H_DATA_HI = 2'd1,
        H_PTR     = 2'd2,
        H_NONE    = 2'd3
    } h_sel_e;

    typedef struct packed {
        logic              we;
        logic [LANES-1:0]  be;
        logic [WORD_W-1:0] wdata;
    } store_op_t;

    function automatic logic [WORD_W-1:0] lane_merge(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w,
        input logic [LANES-1:0]  be
    );
        logic [WORD_W-1:0] r;
        for (int k = 0; k < LANES; k++)
            r[8*k +: 8] = be[k] ? new_w[8*k +: 8] : old_w[8*k +: 8];
        return r;
    endfunction

endpackage

// File: rtl/coram_store.sv
module coram_store
    import coram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] idx,
    input  store_op_t         op,
    output logic [WORD_W-1:0] rd_word,
    output logic              busy
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] sweep;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b1;
            sweep <= '0;
        end else if (busy) begin
            sweep <= sweep + 1'b1;
            if (&sweep)
                busy <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (busy) begin
            mem[sweep] <= '0;
        end else if (op.we) begin
            for (int k = 0; k < LANES; k++)
                if (op.be[k])
                    mem[idx][8*k +: 8] <= op.wdata[8*k +: 8];
        end
        rd_word <= mem[idx];
    end

endmodule

// File: rtl/coram_cp_ptrs.sv
module coram_cp_ptrs
    import coram_pkg::*;
#(
    parameter int SETS = 4,
    localparam int SEL_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  sel,
    input  logic              wr_en,
    input  logic              inc_en,
    input  logic [LANES-1:0]  be,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] cur
);
    logic [SETS-1:0][WORD_W-1:0] ptr;

    for (genvar i = 0; i < SETS; i++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst)
                ptr[i] <= '0;
            else if (wr_en && sel == SEL_W'(i))
                ptr[i] <= lane_merge(ptr[i], wdata, be);
            else if (inc_en && sel == SEL_W'(i))
                ptr[i] <= ptr[i] + 1'b1;
        end
    end

    assign cur = ptr[sel];

endmodule

// File: rtl/coram_host_port.sv
module coram_host_port
    import coram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic              we,
    input  h_sel_e            sel,
    input  logic [HALF_W-1:0] wdata,
    output logic [HALF_W-1:0] ptr,
    output logic [HALF_W-1:0] latch_lo
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr      <= '0;
            latch_lo <= '0;
        end else if (acc) begin
            if (we && sel == H_DATA_LO)
                latch_lo <= wdata;
            if (we && sel == H_PTR)
                ptr <= wdata;
            else if (sel == H_DATA_HI && ptr[HOST_STEP_BIT])
                ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/coram_window.sv
module coram_window
    import coram_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int CP_SETS = 4,
    localparam int SEL_W  = $clog2(CP_SETS),
    localparam int CP_AW  = 3 + SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cp_req,
    input  logic              cp_we,
    input  logic [CP_AW-1:0]  cp_addr,
    input  logic [LANES-1:0]  cp_be,
    input  logic [WORD_W-1:0] cp_wdata,
    output logic [WORD_W-1:0] cp_rdata,
    output logic              cp_rvalid,
    input  logic              h_req,
    input  logic              h_we,
    input  logic [1:0]        h_sel,
    input  logic [HALF_W-1:0] h_wdata,
    output logic              h_ready,
    output logic [HALF_W-1:0] h_rdata,
    output logic              h_rvalid,
    output logic              clr_busy
);
    logic              cp_hit, cp_mem;
    logic              h_wants_store, h_acc, h_store_go;
    h_sel_e            h_kind;
    logic [WORD_W-1:0] cp_ptr, rd_word;
    logic [HALF_W-1:0] host_ptr, latch_lo;
    logic [ADDR_W-1:0] st_idx;
    store_op_t         st_op;

    logic              cp_src_mem;
    logic [WORD_W-1:0] cp_reg_q;
    h_sel_e            h_src;
    logic [HALF_W-1:0] h_reg_q;

    assign h_kind        = h_sel_e'(h_sel);
    assign cp_hit        = cp_req && !clr_busy && (cp_addr[2:1] == 2'b00);
    assign cp_mem        = cp_hit && cp_addr[0];
    assign h_wants_store = (h_kind == H_DATA_HI) || (h_kind == H_DATA_LO && !h_we);
    assign h_ready       = !clr_busy && !(cp_mem && h_req && h_wants_store);
    assign h_acc         = h_req && h_ready;
    assign h_store_go    = h_acc && h_wants_store;

    coram_cp_ptrs #(.SETS(CP_SETS)) u_cp_ptrs (
        .clk    (clk),
        .rst    (rst),
        .sel    (cp_addr[CP_AW-1:3]),
        .wr_en  (cp_hit && !cp_addr[0] && cp_we),
        .inc_en (cp_mem),
        .be     (cp_be),
        .wdata  (cp_wdata),
        .cur    (cp_ptr)
    );

    coram_host_port u_host (
        .clk      (clk),
        .rst      (rst),
        .acc      (h_acc),
        .we       (h_we),
        .sel      (h_kind),
        .wdata    (h_wdata),
        .ptr      (host_ptr),
        .latch_lo (latch_lo)
    );

    always_comb begin
        if (cp_mem) begin
            st_idx      = cp_ptr[ADDR_W-1:0];
            st_op.we    = cp_we;
            st_op.be    = cp_be;
            st_op.wdata = cp_wdata;
        end else begin
            st_idx      = host_ptr[ADDR_W-1:0];
            st_op.we    = h_store_go && h_we;
            st_op.be    = '1;
            st_op.wdata = {h_wdata, latch_lo};
        end
    end

    coram_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .idx     (st_idx),
        .op      (st_op),
        .rd_word (rd_word),
        .busy    (clr_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cp_rvalid  <= 1'b0;
            cp_src_mem <= 1'b0;
            cp_reg_q   <= '0;
            h_rvalid   <= 1'b0;
            h_src      <= H_NONE;
            h_reg_q    <= '0;
        end else begin
            cp_rvalid  <= cp_hit && !cp_we;
            cp_src_mem <= cp_addr[0];
            cp_reg_q   <= cp_ptr;
            h_rvalid   <= h_acc && !h_we;
            h_src      <= h_kind;
            h_reg_q    <= host_ptr;
        end
    end

    assign cp_rdata = cp_src_mem ? rd_word : cp_reg_q;

    always_comb begin
        unique case (h_src)
            H_DATA_LO: h_rdata = rd_word[HALF_W-1:0];
            H_DATA_HI: h_rdata = rd_word[WORD_W-1:HALF_W];
            H_PTR:     h_rdata = h_reg_q;
            default:   h_rdata = '0;
        endcase
    end

endmodule

// File: rtl/coram_window_chk.sv
module coram_window_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        cp_req,
    input logic        cp_we,
    input logic [4:0]  cp_addr,
    input logic        cp_rvalid,
    input logic        h_req,
    input logic [1:0]  h_sel,
    input logic        h_ready,
    input logic        h_rvalid,
    input logic [15:0] hptr
);
    AST_BUSY_ONLY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(rst)); // R1

    AST_BUSY_HOLDS_HOST: assert property (@(posedge clk) disable iff (rst)
        busy |-> !h_ready); // R2

    AST_BUSY_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!cp_rvalid && !h_rvalid)); // R2

    AST_CP_READ_NEXT: assert property (@(posedge clk) disable iff (rst)
        (cp_req && !cp_we && !busy && cp_addr[2:1] == 2'b00) |=> cp_rvalid); // R4

    AST_CP_WINS: assert property (@(posedge clk) disable iff (rst)
        (cp_req && cp_addr[0] && cp_addr[2:1] == 2'b00 && h_req && h_sel == 2'd1) |-> !h_ready); // R10

    AST_HOST_HI_HOLD: assert property (@(posedge clk) disable iff (rst)
        (h_req && h_ready && h_sel == 2'd1 && !hptr[15]) |=> $stable(hptr)); // R8

    AST_HOST_HI_STEP: assert property (@(posedge clk) disable iff (rst)
        (h_req && h_ready && h_sel == 2'd1 && hptr[15]) |=> (hptr == $past(hptr) + 16'd1)); // R8

    AST_HOST_LO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (h_req && h_ready && h_sel == 2'd0) |=> $stable(hptr)); // R8

endmodule

bind coram_window coram_window_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (clr_busy),
    .cp_req    (cp_req),
    .cp_we     (cp_we),
    .cp_addr   (cp_addr),
    .cp_rvalid (cp_rvalid),
    .h_req     (h_req),
    .h_sel     (h_sel),
    .h_ready   (h_ready),
    .h_rvalid  (h_rvalid),
    .hptr      (host_ptr)
);

// File: tb/test_coram_window.sv
module test_coram_window;

    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cp_req = 1'b0, cp_we = 1'b0;
    logic [4:0]  cp_addr = '0;
    logic [3:0]  cp_be = '0;
    logic [31:0] cp_wdata = '0;
    logic [31:0] cp_rdata;
    logic        cp_rvalid;
    logic        h_req = 1'b0, h_we = 1'b0;
    logic [1:0]  h_sel = '0;
    logic [15:0] h_wdata = '0;
    logic        h_ready;
    logic [15:0] h_rdata;
    logic        h_rvalid;
    logic        clr_busy;

    coram_window #(.ADDR_W(AW), .CP_SETS(4)) i_coram_window (
        .clk(clk), .rst(rst),
        .cp_req(cp_req), .cp_we(cp_we), .cp_addr(cp_addr), .cp_be(cp_be),
        .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .cp_rvalid(cp_rvalid),
        .h_req(h_req), .h_we(h_we), .h_sel(h_sel), .h_wdata(h_wdata),
        .h_ready(h_ready), .h_rdata(h_rdata), .h_rvalid(h_rvalid),
        .clr_busy(clr_busy)
    );

    always #5 clk = ~clk;

    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;
    logic [31:0] ref_mem [DEPTH];
    logic [31:0] rp [4];
    logic [15:0] rh, rl0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] bmerge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
        logic [31:0] r = o;
        for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = n[8*k +: 8];
        return r;
    endfunction

    function automatic logic [4:0] cpa(input int set, input bit data);
        return {set[1:0], 2'b00, data};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        for (int i = 0; i < 4; i++) rp[i] = '0;
        rh = '0; rl0 = '0;
    endtask

    task automatic cp_model(input bit we, input logic [4:0] a, input logic [3:0] be,
                            input logic [31:0] d, output bit rd, output logic [31:0] exp);
        int s = int'(a[4:3]);
        rd = 1'b0; exp = '0;
        if (a[2:1] != 2'b00) return;
        if (!a[0]) begin
            if (we) rp[s] = bmerge(rp[s], d, be);
            else begin rd = 1'b1; exp = rp[s]; end
        end else begin
            if (we) ref_mem[rp[s][AW-1:0]] = bmerge(ref_mem[rp[s][AW-1:0]], d, be);
            else begin rd = 1'b1; exp = ref_mem[rp[s][AW-1:0]]; end
            rp[s] = rp[s] + 1;
        end
    endtask

    task automatic h_model(input bit we, input logic [1:0] s, input logic [15:0] d,
                           output logic [15:0] exp);
        logic [31:0] w = ref_mem[rh[AW-1:0]];
        exp = '0;
        case (s)
            2'd0: if (we) rl0 = d; else exp = w[15:0];
            2'd1: begin
                if (we) ref_mem[rh[AW-1:0]] = {d, rl0}; else exp = w[31:16];
                if (rh[15]) rh = rh + 1;
            end
            2'd2: if (we) rh = d; else exp = rh;
            default: exp = '0;
        endcase
    endtask

    task automatic cp_op(input bit we, input logic [4:0] a, input logic [3:0] be,
                         input logic [31:0] d, input string req);
        bit rd; logic [31:0] exp;
        @(negedge clk);
        cp_req = 1'b1; cp_we = we; cp_addr = a; cp_be = be; cp_wdata = d;
        cp_model(we, a, be, d, rd, exp);
        @(negedge clk);
        cp_req = 1'b0;
        chk(cp_rvalid == rd, req, {31'd0, cp_rvalid}, {31'd0, rd});
        if (rd) chk(cp_rdata == exp, req, cp_rdata, exp);
    endtask

    task automatic h_op(input bit we, input logic [1:0] s, input logic [15:0] d, input string req);
        logic [15:0] exp;
        @(negedge clk);
        h_req = 1'b1; h_we = we; h_sel = s; h_wdata = d;
        #1 chk(h_ready == 1'b1, "R10 idle ready", {31'd0, h_ready}, 32'd1);
        h_model(we, s, d, exp);
        @(negedge clk);
        h_req = 1'b0;
        chk(h_rvalid == !we, req, {31'd0, h_rvalid}, {31'd0, !we});
        if (!we) chk(h_rdata == exp, req, {16'd0, h_rdata}, {16'd0, exp});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        model_reset();
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int          cnt;
        logic [15:0] hx;
        logic [31:0] cx;
        bit          rd;
        void'($urandom(32'h5eed_c0de));

        // R1/R2: reset, sweep length, requests ignored while busy
        do_reset();
        cnt = 0;
        chk(clr_busy == 1'b1, "R1 busy at release", {31'd0, clr_busy}, 32'd1);
        cp_req = 1'b1; cp_we = 1'b1; cp_addr = cpa(0, 1); cp_be = 4'hF; cp_wdata = 32'hDEAD_BEEF;
        h_req = 1'b1; h_we = 1'b1; h_sel = 2'd2; h_wdata = 16'h8123;
        #1 chk(h_ready == 1'b0, "R2 ready low while busy", {31'd0, h_ready}, 32'd0);
        cnt++;
        @(negedge clk);
        cp_req = 1'b0; h_req = 1'b0;
        chk(cp_rvalid == 1'b0, "R2 no result while busy", {31'd0, cp_rvalid}, 32'd0);
        while (clr_busy) begin cnt++; @(negedge clk); end
        chk(cnt == DEPTH, "R1 sweep length", cnt, DEPTH);
        cp_op(1'b0, cpa(0, 0), 4'h0, 0, "R2 cp pointer untouched");
        cp_op(1'b0, cpa(0, 1), 4'h0, 0, "R2 word untouched");
        h_op(1'b0, 2'd2, 0, "R2 host pointer untouched");
        // R1: latch cleared, so a lone high write commits zero low half
        h_op(1'b1, 2'd2, 16'h0040, "R6 host pointer write");
        h_op(1'b1, 2'd1, 16'hABCD, "R9 commit with cleared latch");
        cp_op(1'b1, cpa(3, 0), 4'hF, 32'h40, "R3 pointer write");
        cp_op(1'b0, cpa(3, 1), 4'h0, 0, "R1 latch cleared by reset");

        // R3: byte-merged pointer write and read back
        cp_op(1'b1, cpa(1, 0), 4'hF, 32'h1234_5678, "R3 full write");
        cp_op(1'b1, cpa(1, 0), 4'b0101, 32'hAABB_CCDD, "R3 merged write");
        cp_op(1'b0, cpa(1, 0), 4'h0, 0, "R3 merged value");
        // R3: unmapped offsets ignored
        cp_op(1'b1, 5'b01010, 4'hF, 32'h0000_0077, "R3 unmapped write");
        cp_op(1'b0, 5'b01100, 4'h0, 0, "R3 unmapped read");
        cp_op(1'b0, cpa(1, 0), 4'h0, 0, "R3 pointer after unmapped");

        // R4/R5: independent pointers
        for (int s = 0; s < 4; s++) cp_op(1'b1, cpa(s, 0), 4'hF, 32'h100 + 32'(s * 16), "R5 set pointer");
        for (int s = 0; s < 4; s++) cp_op(1'b1, cpa(s, 1), 4'hF, 32'hC0DE_0000 + 32'(s), "R5 data write");
        for (int s = 0; s < 4; s++) cp_op(1'b0, cpa(s, 0), 4'h0, 0, "R5 only own pointer moved");
        cp_op(1'b1, cpa(2, 0), 4'hF, 32'h120, "R4 rewind");
        cp_op(1'b1, cpa(2, 1), 4'b0010, 32'hFFFF_FFFF, "R5 byte write");
        cp_op(1'b1, cpa(2, 0), 4'hF, 32'h120, "R4 rewind");
        cp_op(1'b0, cpa(2, 1), 4'h0, 0, "R4 R5 merged word");
        cp_op(1'b0, cpa(2, 0), 4'h0, 0, "R4 pointer stepped");

        // R11: upper pointer bits do not select the entry
        cp_op(1'b1, cpa(0, 0), 4'hF, 32'hFFFF_0005, "R11 high pointer");
        cp_op(1'b1, cpa(0, 1), 4'hF, 32'h5A5A_1234, "R11 write via high pointer");
        cp_op(1'b0, cpa(0, 0), 4'h0, 0, "R11 upper bits kept");
        cp_op(1'b1, cpa(3, 0), 4'hF, 32'h5, "R11 low pointer");
        cp_op(1'b0, cpa(3, 1), 4'h0, 0, "R11 same entry");

        // R7/R8/R9: host halves, latch, conditional step
        h_op(1'b1, 2'd2, 16'h0010, "R6 pointer no step");
        h_op(1'b1, 2'd0, 16'h1111, "R9 latch low");
        h_op(1'b1, 2'd1, 16'h2222, "R9 commit");
        h_op(1'b0, 2'd2, 0, "R8 no step when bit15 clear");
        h_op(1'b0, 2'd0, 0, "R7 low half");
        h_op(1'b0, 2'd1, 0, "R7 high half");
        h_op(1'b0, 2'd2, 0, "R8 still no step");
        h_op(1'b1, 2'd2, 16'h8020, "R6 pointer with step bit");
        h_op(1'b1, 2'd0, 16'h3333, "R9 latch low");
        h_op(1'b1, 2'd1, 16'h4444, "R9 commit and step");
        h_op(1'b1, 2'd0, 16'h5555, "R9 latch low");
        h_op(1'b1, 2'd1, 16'h6666, "R9 commit and step");
        h_op(1'b0, 2'd2, 0, "R8 stepped twice");
        h_op(1'b0, 2'd0, 0, "R8 low read no step");
        h_op(1'b0, 2'd2, 0, "R8 after low read");
        h_op(1'b0, 2'd3, 0, "R6 offset 3 reads zero");
        cp_op(1'b1, cpa(0, 0), 4'hF, 32'h20, "R9 check pointer");
        cp_op(1'b0, cpa(0, 1), 4'h0, 0, "R9 word one");
        cp_op(1'b0, cpa(0, 1), 4'h0, 0, "R9 word two");

        // R10: collision, coprocessor first
        h_op(1'b1, 2'd2, 16'h0020, "R6 pointer for collision");
        cp_op(1'b1, cpa(0, 0), 4'hF, 32'h21, "R10 cp pointer");
        @(negedge clk);
        cp_req = 1'b1; cp_we = 1'b0; cp_addr = cpa(0, 1); cp_be = 4'h0;
        h_req = 1'b1; h_we = 1'b0; h_sel = 2'd1;
        #1 chk(h_ready == 1'b0, "R10 host stalled", {31'd0, h_ready}, 32'd0);
        cp_model(1'b0, cpa(0, 1), 4'h0, 0, rd, cx);
        @(negedge clk);
        cp_req = 1'b0;
        chk(cp_rvalid == 1'b1, "R10 cp served", {31'd0, cp_rvalid}, 32'd1);
        chk(cp_rdata == cx, "R10 cp data", cp_rdata, cx);
        chk(h_rvalid == 1'b0, "R10 host not yet served", {31'd0, h_rvalid}, 32'd0);
        #1 chk(h_ready == 1'b1, "R10 host ready next", {31'd0, h_ready}, 32'd1);
        h_model(1'b0, 2'd1, 0, hx);
        @(negedge clk);
        h_req = 1'b0;
        chk(h_rvalid == 1'b1, "R10 host served", {31'd0, h_rvalid}, 32'd1);
        chk(h_rdata == hx, "R10 host data", {16'd0, h_rdata}, {16'd0, hx});

        // random mix
        for (int n = 0; n < 500; n++) begin
            int          kind = $urandom_range(0, 9);
            int          s    = $urandom_range(0, 3);
            logic [31:0] rv   = $urandom;
            case (kind)
                0: cp_op(1'b1, cpa(s, 0), 4'($urandom), rv, "R3 random pointer write");
                1: cp_op(1'b0, cpa(s, 0), 4'h0, 0, "R3 random pointer read");
                2, 3: cp_op(1'b1, cpa(s, 1), 4'($urandom), rv, "R5 random data write");
                4: cp_op(1'b0, cpa(s, 1), 4'h0, 0, "R4 random data read");
                5: h_op(1'b1, 2'd2, rv[15:0], "R6 random host pointer");
                6: h_op(1'b1, 2'd0, rv[15:0], "R9 random latch");
                7: h_op(1'b1, 2'd1, rv[15:0], "R9 random commit");
                8: h_op(1'b0, 2'(rv[0]), 0, "R7 random host read");
                default: cp_op(rv[0], {2'(s), 2'(rv[2:1] | 2'b01), rv[3]}, 4'hF, rv, "R3 random unmapped");
            endcase
        end

        // R1: second reset clears every entry
        do_reset();
        while (clr_busy) @(negedge clk);
        for (int i = 0; i < DEPTH; i++) cp_op(1'b0, cpa(2, 1), 4'h0, 0, "R1 entry cleared");
        h_op(1'b0, 2'd2, 0, "R1 host pointer cleared");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule